// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache placed between a processor request port and a slower block-oriented memory port. Each set holds two ways, and every way keeps a tag, a valid bit, a dirty bit and one data block. A request address splits into three fields. The low bits give the byte offset inside a block. The next bits select the set. The remaining upper bits form the tag. Both stored tags of the selected set are compared with the request tag at the same time. The two match results are ORed into a hit, and the matching way drives a 2:1 block multiplexer.

Writes are absorbed by the cache, which sets the block's dirty bit. A miss picks its victim from a single least-recently-used bit per set. If the victim is dirty, it is first written back whole to lower memory. The missing block is then read in, and the lookup is repeated, so a write miss allocates the block and then merges the write into it. The request port accepts one request at a time and signals completion with a one-cycle response pulse.

Top module: `assoc2_wb_cache`

## Requirements
- R1: After reset every way of every set is invalid and clean, so the first access to any address reads its block from memory and writes nothing back; during reset req_ready is high and resp_valid and mem_valid are low.
- R2: Address bits [OFF_W-1:0] are the byte offset, bits [OFF_W+IDX_W-1:OFF_W] the set index, and the upper TAG_W bits the tag; bits [OFF_W-1:2] (for 4-byte words) select the word within a block. Two blocks with the same index and different tags are resident together.
- R3: A read hit returns the addressed word of the matching way on resp_rdata with no memory traffic. resp_valid is high for exactly one cycle, the second cycle after the accepting edge.
- R4: Each set keeps one LRU bit naming the way to replace. A hit or a refill makes the other way the LRU one, and a miss replaces the LRU way.
- R5: A write hit changes only the cache. Byte i of the addressed word (bits 8i+7:8i) is written when req_be[i] is 1, the other bytes keep their value, and the block becomes dirty.
- R6: A block goes to memory only when it is evicted on a miss while dirty. The write-back carries the whole victim block to the victim's own block address and precedes the refill read.
- R7: A write miss first refills the block from memory and then merges the write into it (write-allocate).
- R8: req_ready is high only while the cache is idle. It is low from the accepting edge until the response pulse has ended.
- R9: mem_valid stays high, with mem_addr and mem_write steady, until mem_ack. mem_addr is block aligned (offset bits zero). Word k of a block sits at bits [k*WORD_W +: WORD_W] of mem_wdata and mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | WORD_W | Store data |
| req_be | input | WORD_BYTES | Store byte enables |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | WORD_W | Load data, valid with resp_valid on loads |
| mem_valid | output | 1 | Memory transfer requested |
| mem_write | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | 8*BLOCK_BYTES | Victim block for write-back |
| mem_ack | input | 1 | Memory completes the transfer |
| mem_rdata | input | 8*BLOCK_BYTES | Refill block, valid with mem_ack |

## Verification
The bench builds the cache with 12-bit addresses, 8-byte blocks of two 32-bit words and four sets. That leaves a 7-bit tag and a 2-bit index, so a handful of addresses in one set force conflict misses, LRU victim choice and dirty evictions within a few dozen transactions. With two words per block, word selection and byte-lane merging inside a block are exercised as well. The bench memory answers after a fixed delay, so the held memory request, the order of write-back before refill, and the exact hit latency are all observed.

// File: rtl/c2w_pkg.sv
package c2w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_WRBACK,
      ST_REFILL,
      ST_RESPOND
   } c2w_state_t;

   localparam int NUM_WAYS = 2;

endpackage

// File: rtl/c2w_way_store.sv
module c2w_way_store #(
   parameter int SETS    = 64,
   parameter int IDX_W   = 6,
   parameter int TAG_W   = 21,
   parameter int WORD_W  = 32,
   parameter int WORDS   = 8,
   parameter int WSEL_W  = 3,
   parameter int BE_W    = 4,
   localparam int BLOCK_W = WORD_W * WORDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   idx,
   input  logic               fill_en,
   input  logic [TAG_W-1:0]   fill_tag,
   input  logic [BLOCK_W-1:0] fill_block,
   input  logic               upd_en,
   input  logic [WSEL_W-1:0]  upd_wsel,
   input  logic [BE_W-1:0]    upd_be,
   input  logic [WORD_W-1:0]  upd_wdata,
   output logic               out_valid,
   output logic               out_dirty,
   output logic [TAG_W-1:0]   out_tag,
   output logic [BLOCK_W-1:0] out_block
);

   logic [TAG_W-1:0]   tag_mem [SETS];
   logic [BLOCK_W-1:0] blk_mem [SETS];
   logic [SETS-1:0]    valid_q;
   logic [SETS-1:0]    dirty_q;
   logic [BLOCK_W-1:0] merged;

   assign out_valid = valid_q[idx];
   assign out_dirty = dirty_q[idx];
   assign out_tag   = tag_mem[idx];
   assign out_block = blk_mem[idx];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < BE_W; b++) begin : g_lane
         localparam int LO = w * WORD_W + b * 8;
         assign merged[LO +: 8] = (upd_wsel == WSEL_W'(w) && upd_be[b])
                                  ? upd_wdata[b*8 +: 8] : out_block[LO +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_mem[idx] <= fill_tag;
         blk_mem[idx] <= fill_block;
      end else if (upd_en) begin
         blk_mem[idx] <= merged;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (upd_en) begin
         dirty_q[idx] <= 1'b1;
      end
   end

endmodule

// File: rtl/c2w_lookup.sv
module c2w_lookup #(
   parameter int TAG_W   = 21,
   parameter int BLOCK_W = 256
) (
   input  logic [TAG_W-1:0]   addr_tag,
   input  logic               valid0,
   input  logic               valid1,
   input  logic [TAG_W-1:0]   tag0,
   input  logic [TAG_W-1:0]   tag1,
   input  logic [BLOCK_W-1:0] block0,
   input  logic [BLOCK_W-1:0] block1,
   output logic               hit,
   output logic               hit_way,
   output logic [BLOCK_W-1:0] hit_block
);

   logic match0;
   logic match1;

   assign match0    = valid0 && (tag0 == addr_tag);
   assign match1    = valid1 && (tag1 == addr_tag);
   assign hit       = match0 | match1;
   assign hit_way   = match1;
   assign hit_block = hit_way ? block1 : block0;

endmodule

// File: rtl/c2w_lru.sv
module c2w_lru #(
   parameter int SETS  = 64,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             touch,
   input  logic             touched_way,
   output logic             lru_way
);

   logic [SETS-1:0] bits_q;

   assign lru_way = bits_q[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (touch) begin
         bits_q[idx] <= ~touched_way;
      end
   end

endmodule

// File: rtl/assoc2_wb_cache.sv
module assoc2_wb_cache
   import c2w_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_BYTES  = 4,
   parameter int BLOCK_BYTES = 32,
   parameter int SETS        = 64,
   localparam int WORD_W  = 8 * WORD_BYTES,
   localparam int BLOCK_W = 8 * BLOCK_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [WORD_W-1:0]     req_wdata,
   input  logic [WORD_BYTES-1:0] req_be,
   output logic                  resp_valid,
   output logic [WORD_W-1:0]     resp_rdata,
   output logic                  mem_valid,
   output logic                  mem_write,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [BLOCK_W-1:0]    mem_wdata,
   input  logic                  mem_ack,
   input  logic [BLOCK_W-1:0]    mem_rdata
);

   localparam int WORDS  = BLOCK_BYTES / WORD_BYTES;
   localparam int OFF_W  = $clog2(BLOCK_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int BSEL_W = $clog2(WORD_BYTES);
   localparam int WSEL_W = $clog2(WORDS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

   if (WORD_BYTES < 1 || (1 << BSEL_W) != WORD_BYTES) begin : g_bad_word
      $error("WORD_BYTES must be a power of two");
   end
   if (WORDS < 2 || (1 << OFF_W) != BLOCK_BYTES || BLOCK_BYTES % WORD_BYTES != 0) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two holding at least two words");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the chosen geometry");
   end

   c2w_state_t              state_q;
   logic [ADDR_W-1:0]       addr_q;
   logic                    write_q;
   logic [WORD_W-1:0]       wdata_q;
   logic [WORD_BYTES-1:0]   be_q;
   logic [WORD_W-1:0]       rdata_q;

   logic [TAG_W-1:0]        tag_f;
   logic [IDX_W-1:0]        idx_f;
   logic [WSEL_W-1:0]       wsel_f;
   logic                    unused_lsb;

   logic [NUM_WAYS-1:0]     w_valid;
   logic [NUM_WAYS-1:0]     w_dirty;
   logic [TAG_W-1:0]        w_tag [NUM_WAYS];
   logic [BLOCK_W-1:0]      w_blk [NUM_WAYS];
   logic [NUM_WAYS-1:0]     fill_en;
   logic [NUM_WAYS-1:0]     upd_en;

   logic                    hit;
   logic                    hit_way;
   logic [BLOCK_W-1:0]      hit_blk;
   logic [WORD_W-1:0]       hit_word;
   logic                    victim;
   logic                    victim_dirty;
   logic                    lru_touch;
   logic                    lru_way_in;
   logic                    refill_done;

   assign tag_f      = addr_q[ADDR_W-1 -: TAG_W];
   assign idx_f      = addr_q[OFF_W +: IDX_W];
   assign wsel_f     = addr_q[BSEL_W +: WSEL_W];
   assign unused_lsb = ^addr_q[OFF_W-1:0];

   assign refill_done = (state_q == ST_REFILL) && mem_ack;

   for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
      assign fill_en[g] = refill_done && (victim == 1'(g));
      assign upd_en[g]  = (state_q == ST_LOOKUP) && hit && write_q && (hit_way == 1'(g));

      c2w_way_store #(
         .SETS   (SETS),
         .IDX_W  (IDX_W),
         .TAG_W  (TAG_W),
         .WORD_W (WORD_W),
         .WORDS  (WORDS),
         .WSEL_W (WSEL_W),
         .BE_W   (WORD_BYTES)
      ) u_store (
         .clk        (clk),
         .rst_n      (rst_n),
         .idx        (idx_f),
         .fill_en    (fill_en[g]),
         .fill_tag   (tag_f),
         .fill_block (mem_rdata),
         .upd_en     (upd_en[g]),
         .upd_wsel   (wsel_f),
         .upd_be     (be_q),
         .upd_wdata  (wdata_q),
         .out_valid  (w_valid[g]),
         .out_dirty  (w_dirty[g]),
         .out_tag    (w_tag[g]),
         .out_block  (w_blk[g])
      );
   end

   c2w_lookup #(
      .TAG_W   (TAG_W),
      .BLOCK_W (BLOCK_W)
   ) u_lookup (
      .addr_tag  (tag_f),
      .valid0    (w_valid[0]),
      .valid1    (w_valid[1]),
      .tag0      (w_tag[0]),
      .tag1      (w_tag[1]),
      .block0    (w_blk[0]),
      .block1    (w_blk[1]),
      .hit       (hit),
      .hit_way   (hit_way),
      .hit_block (hit_blk)
   );

   assign lru_touch  = ((state_q == ST_LOOKUP) && hit) || refill_done;
   assign lru_way_in = (state_q == ST_LOOKUP) ? hit_way : victim;

   c2w_lru #(
      .SETS  (SETS),
      .IDX_W (IDX_W)
   ) u_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx         (idx_f),
      .touch       (lru_touch),
      .touched_way (lru_way_in),
      .lru_way     (victim)
   );

   assign victim_dirty = w_valid[victim] && w_dirty[victim];
   assign hit_word     = hit_blk[wsel_f*WORD_W +: WORD_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:    if (req_valid) state_q <= ST_LOOKUP;
            ST_LOOKUP:  begin
               if (hit)               state_q <= ST_RESPOND;
               else if (victim_dirty) state_q <= ST_WRBACK;
               else                   state_q <= ST_REFILL;
            end
            ST_WRBACK:  if (mem_ack) state_q <= ST_REFILL;
            ST_REFILL:  if (mem_ack) state_q <= ST_LOOKUP;
            ST_RESPOND: state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == ST_IDLE && req_valid) begin
         addr_q  <= req_addr;
         write_q <= req_write;
         wdata_q <= req_wdata;
         be_q    <= req_be;
      end
      if (state_q == ST_LOOKUP && hit) begin
         rdata_q <= hit_word;
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign resp_valid = (state_q == ST_RESPOND);
   assign resp_rdata = rdata_q;
   assign mem_valid  = (state_q == ST_WRBACK) || (state_q == ST_REFILL);
   assign mem_write  = (state_q == ST_WRBACK);
   assign mem_addr   = (state_q == ST_WRBACK) ? {w_tag[victim], idx_f, {OFF_W{1'b0}}}
                                              : {tag_f, idx_f, {OFF_W{1'b0}}};
   assign mem_wdata  = w_blk[victim];

endmodule

// File: rtl/assoc2_wb_cache_chk.sv
module assoc2_wb_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              resp_valid,
   input logic              mem_valid,
   input logic              mem_write,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr
);

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R8
   resp_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (!req_ready && !mem_valid));

   // R3
   resp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

   // R9
   mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

   // R6
   refill_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && mem_ack) |=> (mem_valid && !mem_write));

endmodule

bind assoc2_wb_cache assoc2_wb_cache_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .resp_valid (resp_valid),
   .mem_valid  (mem_valid),
   .mem_write  (mem_write),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr)
);

// File: tb/assoc2_wb_cache_test.sv
module assoc2_wb_cache_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW      = 12;
   localparam int WB      = 4;
   localparam int BB      = 8;
   localparam int NSETS   = 4;
   localparam int NWORDS  = BB / WB;
   localparam int BW      = 8 * BB;
   localparam int MEMW    = (1 << AW) / WB;
   localparam int MEM_LAT = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic            req_write = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [31:0]     req_wdata = '0;
   logic [3:0]      req_be = '0;
   logic            resp_valid;
   logic [31:0]     resp_rdata;
   logic            mem_valid;
   logic            mem_write;
   logic [AW-1:0]   mem_addr;
   logic [BW-1:0]   mem_wdata;
   logic            mem_ack = 1'b0;
   logic [BW-1:0]   mem_rdata = '0;

   int total = 0;
   int fails = 0;

   logic [31:0] bmem [MEMW];
   logic [31:0] gmem [MEMW];
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   int          lat_cnt = 0;
   logic [AW-1:0] last_wr_addr = '0;
   logic [BW-1:0] last_wr_data = '0;
   int          mis_align = 0;

   int          m_tag  [2][NSETS];
   bit          m_val  [2][NSETS];
   bit          m_dirty[2][NSETS];
   int          m_lru  [NSETS];
   logic [31:0] m_data [2][NSETS][NWORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   assoc2_wb_cache #(
      .ADDR_W (AW), .WORD_BYTES (WB), .BLOCK_BYTES (BB), .SETS (NSETS)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
      .resp_valid (resp_valid), .resp_rdata (resp_rdata),
      .mem_valid (mem_valid), .mem_write (mem_write), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
   );

   // Memory responder: acknowledges after MEM_LAT idle negedges.
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         lat_cnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
         lat_cnt = 0;
      end else if (mem_valid) begin
         if (mem_addr % BB != 0) mis_align++;
         if (lat_cnt == MEM_LAT) begin
            mem_ack = 1'b1;
            if (mem_write) begin
               wr_cnt++;
               last_wr_addr = mem_addr;
               last_wr_data = mem_wdata;
               for (int k = 0; k < NWORDS; k++) bmem[mem_addr/WB + k] = mem_wdata[k*32 +: 32];
            end else begin
               rd_cnt++;
               for (int k = 0; k < NWORDS; k++) mem_rdata[k*32 +: 32] = bmem[mem_addr/WB + k];
            end
         end else begin
            lat_cnt++;
         end
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic access(input bit wr, input int a, input logic [31:0] wd,
                         input logic [3:0] be, input string rq);
      int idx  = (a / BB) % NSETS;
      int tg   = a / (BB * NSETS);
      int ws   = (a / WB) % NWORDS;
      int hw   = -1;
      bit hit;
      bit exp_wb = 0;
      int wb_addr = 0;
      logic [BW-1:0] wb_blk = '0;
      logic [31:0] exp_rd;
      int wc0, rc0, n;
      bit got = 0;
      bit ready_bad = 0;

      for (int w = 0; w < 2; w++)
         if (m_val[w][idx] && m_tag[w][idx] == tg) hw = w;
      hit = (hw >= 0);
      if (!hit) begin
         int v = m_lru[idx];
         if (m_val[v][idx] && m_dirty[v][idx]) begin
            exp_wb  = 1;
            wb_addr = (m_tag[v][idx] * NSETS + idx) * BB;
            for (int k = 0; k < NWORDS; k++) begin
               gmem[wb_addr/WB + k] = m_data[v][idx][k];
               wb_blk[k*32 +: 32] = m_data[v][idx][k];
            end
         end
         for (int k = 0; k < NWORDS; k++)
            m_data[v][idx][k] = gmem[(a / BB) * NWORDS + k];
         m_tag[v][idx] = tg;
         m_val[v][idx] = 1;
         m_dirty[v][idx] = 0;
         hw = v;
      end
      m_lru[idx] = 1 - hw;
      exp_rd = m_data[hw][idx][ws];
      if (wr) begin
         for (int b = 0; b < 4; b++)
            if (be[b]) m_data[hw][idx][ws][b*8 +: 8] = wd[b*8 +: 8];
         m_dirty[hw][idx] = 1;
      end

      wc0 = wr_cnt;
      rc0 = rd_cnt;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = AW'(a);
      req_wdata = wd;
      req_be    = be;
      #1;
      check(req_ready == 1'b1, "R8", "ready before accept", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      if (resp_valid) got = 1;
      while (!got && n < 300) begin
         if (req_ready) ready_bad = 1;
         @(negedge clk);
         n++;
         if (resp_valid) got = 1;
      end
      if (req_ready) ready_bad = 1;
      check(got, rq, "response seen", 64'(got), 64'd1);
      check(!ready_bad, "R8", "ready low while busy", 64'(ready_bad), 64'd0);
      if (hit)
         check(n == 2, "R3", "hit response cycle", 64'(n), 64'd2);
      check(wr_cnt - wc0 == int'(exp_wb), "R6", "write-back count", 64'(wr_cnt - wc0), 64'(exp_wb));
      check(rd_cnt - rc0 == int'(!hit), "R4", "refill count", 64'(rd_cnt - rc0), 64'(!hit));
      if (exp_wb) begin
         check(last_wr_addr == AW'(wb_addr), "R6", "write-back address", 64'(last_wr_addr), 64'(wb_addr));
         check(last_wr_data == wb_blk, "R6", "write-back block", last_wr_data, wb_blk);
      end
      if (!wr)
         check(resp_rdata == exp_rd, rq, "read data", 64'(resp_rdata), 64'(exp_rd));
      @(negedge clk);
      check(req_ready == 1'b1 && resp_valid == 1'b0, "R8", "idle after response",
            64'({req_ready, resp_valid}), 64'b10);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEMW; i++) begin
         bmem[i] = (32'(i) * 32'h0101_0101) ^ 32'hA500_3C00;
         gmem[i] = bmem[i];
      end
      for (int s = 0; s < NSETS; s++) begin
         m_lru[s] = 0;
         for (int w = 0; w < 2; w++) begin
            m_val[w][s] = 0;
            m_dirty[w][s] = 0;
            m_tag[w][s] = 0;
         end
      end

      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
      check(resp_valid == 1'b0, "R1", "resp in reset", 64'(resp_valid), 64'd0);
      check(mem_valid == 1'b0, "R1", "mem request in reset", 64'(mem_valid), 64'd0);
      rst_n = 1'b1;

      // Set 1 addresses: A=0x008, B=0x028, C=0x048, D=0x068 (R2 field split)
      access(0, 'h008, 0, 0, "R1");                 // cold miss, no write-back
      access(0, 'h00C, 0, 0, "R3");                 // hit, second word
      access(0, 'h028, 0, 0, "R2");                 // same index, other tag
      access(0, 'h008, 0, 0, "R2");                 // A still resident
      access(0, 'h02C, 0, 0, "R2");                 // B still resident
      access(1, 'h008, 32'h1122_3344, 4'b0101, "R5"); // write hit, lanes 0 and 2
      access(0, 'h008, 0, 0, "R5");                 // merged word read back
      check(wr_cnt == 0, "R5", "no memory write on write hit", 64'(wr_cnt), 64'd0);
      access(0, 'h048, 0, 0, "R4");                 // evicts clean B (LRU)
      access(0, 'h00C, 0, 0, "R4");                 // A survives
      access(1, 'h06C, 32'hDEAD_BEEF, 4'b1111, "R7"); // write miss allocates
      access(0, 'h06C, 0, 0, "R7");                 // merged write visible
      access(0, 'h008, 0, 0, "R4");
      access(0, 'h028, 0, 0, "R6");                 // evicts dirty D
      access(0, 'h06C, 0, 0, "R6");                 // evicts dirty A, D comes back
      access(0, 'h008, 0, 0, "R6");                 // A's merged data from memory
      // other sets: byte lanes 1 and 3 and set 2 traffic
      access(1, 'h110, 32'hCAFE_F00D, 4'b1010, "R7");
      access(0, 'h110, 0, 0, "R5");
      access(0, 'h190, 0, 0, "R4");
      access(0, 'h210, 0, 0, "R6");
      access(0, 'h114, 0, 0, "R3");
      check(mis_align == 0, "R9", "block aligned memory address", 64'(mis_align), 64'd0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule